// File: doc/BRIEF.md
# Port Sequence Error Detector

This block confirms that overhead service goes only to minor frames that may receive it. A minor frame may receive service when its 5-bit frame count is no greater than the configured number of ports in use. A frame whose count is above that number must not receive service. The block compares the count with the setting, and the result is the frame's eligibility.

Each minor frame contains a designated word-28 window. During that window the block watches a service strobe. When the window closes, the block compares two things: whether the strobe was seen, and whether the frame was eligible. If they disagree, it raises a one-cycle error pulse. Two cases give an error: an eligible frame with no strobe, and an ineligible frame with a strobe.

All state advances only on clock cycles where the system clock enable is high. Each window begins with a fresh capture. The frame counter itself comes from elsewhere.

Top module: `port_seq_check`

## Requirements
- R1: After a synchronous reset, `seq_err` is 0 and the capture state is clear, so the next frame is judged without history.
- R2: A frame is eligible when `frame_cnt` <= `ports_used` (unsigned, 5 bits). It is ineligible when `frame_cnt` > `ports_used`. Eligibility is sampled while the window is high.
- R3: An eligible frame with the strobe seen inside the window produces no error.
- R4: An eligible frame with no strobe inside the window produces an error pulse.
- R5: An ineligible frame with the strobe inside the window produces an error pulse.
- R6: An ineligible frame with no strobe produces no error.
- R7: A strobe while `win_w28` is low has no effect on the capture or on the error.
- R8: The closing of the window is seen at the first enabled edge where `win_w28` is 0 after being 1. `seq_err` is 1 for exactly the one clock cycle after that edge.
- R9: While `clk_en` is 0, strobes, window changes and count changes are not registered. A window closing is judged only at the next enabled edge.
- R10: The capture is reloaded when each window opens, so a strobe from an earlier frame does not count toward a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | System clock enable; state advances only when high |
| win_w28 | input | 1 | High during word 28 of the minor frame |
| svc_strobe | input | 1 | Port-sequence service strobe |
| frame_cnt | input | 5 | Minor frame count |
| ports_used | input | 5 | Number of ports in use |
| seq_err | output | 1 | One-cycle active-high sequence error pulse |

## Verification
A capture bit that is stuck, or that is not reloaded when a window opens, shows up at the end of the very next window. It appears as an error pulse where none belongs, or as a missing pulse. An off-by-one in the comparison appears only when `frame_cnt` equals `ports_used` or exceeds it by one, so the bench sweeps the setting across all 32 values at those boundaries. A window edge detector that ignores the enable would fire while the enable is low. A detector that runs late would move the pulse by a cycle, and the checks sample in the single expected cycle, so either fault is caught.

// File: rtl/pse_pkg.sv
package pse_pkg;
    localparam int CNT_W = 5;

    typedef logic [CNT_W-1:0] cnt_t;

    // Result of watching one word-28 window
    typedef struct packed {
        logic seen;   // strobe observed inside the window
        logic elig;   // frame count within ports in use
    } snap_t;

    function automatic logic is_eligible(input cnt_t cnt, input cnt_t used);
        return !(cnt > used);
    endfunction
endpackage

// File: rtl/pse_window_edge.sv
module pse_window_edge (
    input  logic clk,
    input  logic rst,
    input  logic clk_en,
    input  logic win_in,
    output logic win_q,
    output logic win_rise,
    output logic win_fall
);
    always_ff @(posedge clk) begin
        if (rst)         win_q <= 1'b0;
        else if (clk_en) win_q <= win_in;
    end

    assign win_rise = clk_en &  win_in & ~win_q;
    assign win_fall = clk_en & ~win_in &  win_q;

    AST_WIN_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(win_q)); // R9
endmodule

// File: rtl/pse_capture.sv
module pse_capture
    import pse_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clk_en,
    input  logic  win_in,
    input  logic  win_rise,
    input  logic  strobe,
    input  cnt_t  cnt,
    input  cnt_t  used,
    output snap_t snap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
        end else if (clk_en && win_in) begin
            snap.elig <= is_eligible(cnt, used);
            if (win_rise)    snap.seen <= strobe;
            else if (strobe) snap.seen <= 1'b1;
        end
    end

    AST_SEEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (snap.seen && !win_rise) |=> snap.seen || $past(win_rise) || win_rise); // R3
    AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        !win_in |=> $stable(snap)); // R7
    AST_IDLE_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(snap)); // R9
    AST_FRESH_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (win_rise && !strobe) |=> !snap.seen); // R10
endmodule

// File: rtl/pse_judge.sv
module pse_judge
    import pse_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  win_fall,
    input  snap_t snap,
    output logic  err
);
    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= win_fall & (snap.seen ^ snap.elig);
    end

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        err |=> !err); // R8
endmodule

// File: rtl/port_seq_check.sv
module port_seq_check
    import pse_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clk_en,
    input  logic         win_w28,
    input  logic         svc_strobe,
    input  logic [W-1:0] frame_cnt,
    input  logic [W-1:0] ports_used,
    output logic         seq_err
);
    logic  win_q, win_rise, win_fall;
    snap_t snap;

    pse_window_edge u_edge (
        .clk(clk), .rst(rst), .clk_en(clk_en), .win_in(win_w28),
        .win_q(win_q), .win_rise(win_rise), .win_fall(win_fall)
    );

    pse_capture u_cap (
        .clk(clk), .rst(rst), .clk_en(clk_en), .win_in(win_w28),
        .win_rise(win_rise), .strobe(svc_strobe),
        .cnt(cnt_t'(frame_cnt)), .used(cnt_t'(ports_used)), .snap(snap)
    );

    pse_judge u_judge (
        .clk(clk), .rst(rst), .win_fall(win_fall), .snap(snap), .err(seq_err)
    );

    AST_ERR_AFTER_CLOSE: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> !win_q); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !seq_err); // R1
endmodule

// File: tb/test_port_seq_check.sv
module test_port_seq_check;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_en = 1'b1;
    logic       win_w28 = 1'b0;
    logic       svc_strobe = 1'b0;
    logic [4:0] frame_cnt = '0;
    logic [4:0] ports_used = '0;
    logic       seq_err;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    port_seq_check i_port_seq_check (
        .clk(clk), .rst(rst), .clk_en(clk_en), .win_w28(win_w28),
        .svc_strobe(svc_strobe), .frame_cnt(frame_cnt),
        .ports_used(ports_used), .seq_err(seq_err)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: seq_err=%0b expected %0b", req, act, exp);
        end
    endtask

    // One frame: a strobe outside the window (optional), 3 window cycles with a
    // strobe in the middle (optional), then the window closes.
    task automatic frame(input int cnt, input int pu, input bit s_in,
                         input bit s_out, input string req);
        logic exp;
        exp = s_in ^ (cnt <= pu);
        @(negedge clk);
        frame_cnt = 5'(cnt); ports_used = 5'(pu);
        win_w28 = 1'b0; svc_strobe = s_out;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            win_w28 = 1'b1; svc_strobe = s_in && (i == 1);
        end
        @(negedge clk);
        win_w28 = 1'b0; svc_strobe = s_out;
        @(posedge clk); #1;
        check(seq_err, exp, req);
        @(posedge clk); #1;
        check(seq_err, 1'b0, "R8 pulse width");
        svc_strobe = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk); #1;
        check(seq_err, 1'b0, "R1 reset");
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check(seq_err, 1'b0, "R1 after reset");
    endtask

    task automatic t_sweep();
        for (int p = 0; p < 32; p++) begin
            frame(p, p, 1'b1, 1'b0, "R2 R3 equal count eligible");
            if (p < 31) frame(p + 1, p, 1'b0, 1'b0, "R2 R6 count above");
            frame(0, p, 1'b0, 1'b0, "R4 missing strobe");
            if (p < 31) frame(31, p, 1'b1, 1'b0, "R5 spurious strobe");
        end
    endtask

    task automatic t_outside();
        frame(3, 10, 1'b0, 1'b1, "R7 outside strobe eligible");
        frame(20, 10, 1'b0, 1'b1, "R7 outside strobe ineligible");
    endtask

    task automatic t_carry();
        frame(2, 5, 1'b1, 1'b0, "R10 first frame");
        frame(9, 5, 1'b0, 1'b0, "R10 no carry-over");
    endtask

    task automatic t_enable();
        // Eligible frame; strobe only while enable is low, so it is missed.
        @(negedge clk);
        frame_cnt = 5'd1; ports_used = 5'd4; clk_en = 1'b1; win_w28 = 1'b1;
        @(negedge clk); clk_en = 1'b0; svc_strobe = 1'b1;
        @(negedge clk); svc_strobe = 1'b0; win_w28 = 1'b0;
        repeat (3) begin
            @(posedge clk); #1;
            check(seq_err, 1'b0, "R9 no judgement while disabled");
        end
        @(negedge clk); clk_en = 1'b1;
        @(posedge clk); #1;
        check(seq_err, 1'b1, "R9 judged at enabled edge");
        @(posedge clk); #1;
        check(seq_err, 1'b0, "R8 pulse width after enable");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: expected 0 hang, got 1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_sweep();
        t_outside();
        t_carry();
        t_enable();
        t_reset();
        frame(4, 4, 1'b0, 1'b0, "R1 R4 first frame after reset");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule